// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port Controller

This block controls one port of sixteen digital pins. A word-wide register bus sets, for each pin, a function (input, driven output, peripheral-owned output, or analog), an output stage type (push-pull or emulated open-drain), a pull resistor choice, a two-bit drive speed code, and a four-bit peripheral source select. A port-wide output latch holds the software-driven pin levels. Software can update the latch by a plain write, or by a set/clear write that changes only the named bits without a read-modify-write sequence.

Each pin's drive source is either its bit of the output latch or one of sixteen peripheral output lines, chosen by that pin's source select. The block turns the chosen value and the pin configuration into pad controls: output enable, drive level, pull-up enable and pull-down enable. The speed code goes to the pad as stored. Pin levels come back through a two-flop synchronizer and can be read as the input data word.

The bus is a plain request/response port with no back-pressure. Every request is accepted in the cycle it is presented. A write updates state at that clock edge. A read returns its data, with `rsp_valid` high, exactly one cycle later. No request ever stalls, so there is no ready signal. Pad outputs are combinational from the stored state, so they follow a write in the cycle right after its edge.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every stored field and the output latch are 0. Every register reads 0, and all pad enables, drive levels and speed codes are 0.
- R2: Word 0 holds the pin function, two bits per pin at bits 2p+1:2p: 00 input, 01 driven output, 10 peripheral output, 11 analog. The output enable can be high only in codes 01 and 10. In analog mode the output enable and both pulls are forced off.
- R3: Word 1 bit p selects the output stage: 0 is push-pull, 1 is open-drain. In push-pull the pin is enabled and its drive level equals the source value. In open-drain the drive level is 0 and the enable is high only while the source value is 0. Pins that are not driving show drive level 0.
- R4: A write to word 6 sets latch bit n for each 1 in write bit n (n < 16). It clears latch bit n for each 1 in write bit n+16. If both bits are 1 for one pin, the set wins. Zero bits leave the latch unchanged. Word 5 is the latch itself and can be read and written directly.
- R5: Word 6 always reads as 0.
- R6: The source select is 4 bits per pin. Pin p < 8 uses word 7 bits 4p+3:4p, and pin p >= 8 uses word 8 bits 4(p-8)+3:4(p-8). In peripheral mode the source value is `af_dout[16*s + p]`, where s is the select; in driven-output mode it is latch bit p.
- R7: Word 3 holds the pull choice, two bits per pin: 01 enables the pull-up, 10 enables the pull-down, and 00 or 11 enables neither. Analog mode overrides all of these to off.
- R8: Word 4 (read only) returns `pad_in` through two synchronizer flops, for every pin function, except that pins in analog mode read 0.
- R9: Word 2 holds a two-bit speed code per pin. It is read back as written and appears unchanged on `pad_speed`.
- R10: A read request gives `rsp_valid` high in the next cycle with the addressed data. A cycle after a write request or after no request gives `rsp_valid` low.
- R11: Words 9 to 15 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Word index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read request) |
| rsp_data | output | 32 | Read data |
| pad_in | input | 16 | Pin levels from the pads (asynchronous) |
| af_dout | input | 256 | Peripheral output lines, bit 16*s+p is source s for pin p |
| pad_oe | output | 16 | Per-pin output enable |
| pad_do | output | 16 | Per-pin drive level |
| pad_pu_en | output | 16 | Per-pin pull-up enable |
| pad_pd_en | output | 16 | Per-pin pull-down enable |
| pad_speed | output | 32 | Per-pin two-bit speed code |

## Verification
The hardest case to reach is a pin in peripheral mode and open-drain at the same time. Here the output enable depends on a peripheral line chosen by a select that lives in one of two split registers. Mode, stage type, source select and the peripheral line pattern must all line up for each pin. The stimulus programs all sixteen selects as a rotation of a sweep index, so every pin visits every source across the sweep. It varies the peripheral line pattern with that index and repeats the sweep with open-drain on. The set/clear rules are exercised with overlapping set and clear words. Their results are read back through the latch word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_IN  = 2'b00,
    PM_OUT = 2'b01,
    PM_ALT = 2'b10,
    PM_ANA = 2'b11
  } pin_mode_e;

  localparam logic [1:0] PULL_UP = 2'b01;
  localparam logic [1:0] PULL_DN = 2'b10;

  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] A_MODE   = 4'd0;
  localparam logic [REG_AW-1:0] A_OTYPE  = 4'd1;
  localparam logic [REG_AW-1:0] A_SPEED  = 4'd2;
  localparam logic [REG_AW-1:0] A_PULL   = 4'd3;
  localparam logic [REG_AW-1:0] A_IDR    = 4'd4;
  localparam logic [REG_AW-1:0] A_ODR    = 4'd5;
  localparam logic [REG_AW-1:0] A_SETCLR = 4'd6;
  localparam logic [REG_AW-1:0] A_AFL    = 4'd7;
  localparam logic [REG_AW-1:0] A_AFH    = 4'd8;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_in;
      stable_q <= meta_q;
    end
  end

  assign sync_out = stable_q;

endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_port_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int NAF = 1 << SEL_W
) (
  input  logic [1:0]       mode,
  input  logic             open_drain,
  input  logic [1:0]       pull,
  input  logic             latch_val,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [NAF-1:0]   af_vec,
  output logic             oe,
  output logic             dout,
  output logic             pu_en,
  output logic             pd_en,
  output logic             is_analog
);

  logic src_val;
  logic driving;

  always_comb begin
    src_val   = (mode == PM_ALT) ? af_vec[src_sel] : latch_val;
    driving   = (mode == PM_OUT) || (mode == PM_ALT);
    is_analog = (mode == PM_ANA);
    if (!driving) begin
      oe   = 1'b0;
      dout = 1'b0;
    end else if (open_drain) begin
      oe   = ~src_val;
      dout = 1'b0;
    end else begin
      oe   = 1'b1;
      dout = src_val;
    end
    pu_en = !is_analog && (pull == PULL_UP);
    pd_en = !is_analog && (pull == PULL_DN);
  end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 32,
  localparam int HALF  = NPINS / 2,
  localparam int AFR_W = HALF * SEL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [REG_AW-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [NPINS-1:0]       idr_val,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [2*NPINS-1:0]     mode_q,
  output logic [NPINS-1:0]       otype_q,
  output logic [2*NPINS-1:0]     speed_q,
  output logic [2*NPINS-1:0]     pull_q,
  output logic [NPINS-1:0]       odr_q,
  output logic [SEL_W*NPINS-1:0] afsel_q
);

  logic [AFR_W-1:0]  afl_q;
  logic [AFR_W-1:0]  afh_q;
  logic              wr_en;
  logic              rd_en;
  logic [NPINS-1:0]  set_bits;
  logic [NPINS-1:0]  clr_bits;
  logic [DATA_W-1:0] rd_next;

  assign wr_en    = req_valid && req_write;
  assign rd_en    = req_valid && !req_write;
  assign set_bits = req_wdata[NPINS-1:0];
  assign clr_bits = req_wdata[NPINS +: NPINS];
  assign afsel_q  = {afh_q, afl_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      odr_q   <= '0;
      afl_q   <= '0;
      afh_q   <= '0;
    end else if (wr_en) begin
      case (req_addr)
        A_MODE:   mode_q  <= req_wdata[2*NPINS-1:0];
        A_OTYPE:  otype_q <= req_wdata[NPINS-1:0];
        A_SPEED:  speed_q <= req_wdata[2*NPINS-1:0];
        A_PULL:   pull_q  <= req_wdata[2*NPINS-1:0];
        A_ODR:    odr_q   <= req_wdata[NPINS-1:0];
        A_SETCLR: odr_q   <= (odr_q & ~clr_bits) | set_bits;
        A_AFL:    afl_q   <= req_wdata[AFR_W-1:0];
        A_AFH:    afh_q   <= req_wdata[AFR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (req_addr)
      A_MODE:  rd_next[2*NPINS-1:0] = mode_q;
      A_OTYPE: rd_next[NPINS-1:0]   = otype_q;
      A_SPEED: rd_next[2*NPINS-1:0] = speed_q;
      A_PULL:  rd_next[2*NPINS-1:0] = pull_q;
      A_IDR:   rd_next[NPINS-1:0]   = idr_val;
      A_ODR:   rd_next[NPINS-1:0]   = odr_q;
      A_AFL:   rd_next[AFR_W-1:0]   = afl_q;
      A_AFH:   rd_next[AFR_W-1:0]   = afh_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_data  <= rd_en ? rd_next : '0;
    end
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int SEL_W  = 4,
  parameter int DATA_W = 32,
  localparam int NAF   = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [REG_AW-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data,
  input  logic [NPINS-1:0]     pad_in,
  input  logic [NAF*NPINS-1:0] af_dout,
  output logic [NPINS-1:0]     pad_oe,
  output logic [NPINS-1:0]     pad_do,
  output logic [NPINS-1:0]     pad_pu_en,
  output logic [NPINS-1:0]     pad_pd_en,
  output logic [2*NPINS-1:0]   pad_speed
);

  logic [2*NPINS-1:0]     mode_q;
  logic [NPINS-1:0]       otype_q;
  logic [2*NPINS-1:0]     speed_q;
  logic [2*NPINS-1:0]     pull_q;
  logic [NPINS-1:0]       odr_q;
  logic [SEL_W*NPINS-1:0] afsel_q;
  logic [NPINS-1:0]       in_sync;
  logic [NPINS-1:0]       ana_mask;
  logic [NPINS-1:0]       idr_val;

  gpio_cfg_regs #(
    .NPINS (NPINS),
    .SEL_W (SEL_W),
    .DATA_W(DATA_W)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .idr_val  (idr_val),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .mode_q   (mode_q),
    .otype_q  (otype_q),
    .speed_q  (speed_q),
    .pull_q   (pull_q),
    .odr_q    (odr_q),
    .afsel_q  (afsel_q)
  );

  gpio_in_sync #(.W(NPINS)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pad_in),
    .sync_out(in_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [NAF-1:0] af_vec;
    for (genvar s = 0; s < NAF; s++) begin : g_src
      assign af_vec[s] = af_dout[s*NPINS + p];
    end
    gpio_pin_drv #(.SEL_W(SEL_W)) drv_i (
      .mode      (mode_q[2*p +: 2]),
      .open_drain(otype_q[p]),
      .pull      (pull_q[2*p +: 2]),
      .latch_val (odr_q[p]),
      .src_sel   (afsel_q[SEL_W*p +: SEL_W]),
      .af_vec    (af_vec),
      .oe        (pad_oe[p]),
      .dout      (pad_do[p]),
      .pu_en     (pad_pu_en[p]),
      .pd_en     (pad_pd_en[p]),
      .is_analog (ana_mask[p])
    );
  end

  assign idr_val   = in_sync & ~ana_mask;
  assign pad_speed = speed_q;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [REG_AW-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_wdata,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_data,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_do,
  input logic [NPINS-1:0]   pad_pu_en,
  input logic [NPINS-1:0]   pad_pd_en,
  input logic [2*NPINS-1:0] mode_q,
  input logic [NPINS-1:0]   otype_q,
  input logic [NPINS-1:0]   odr_q
);

  logic [NPINS-1:0] m_ana;
  logic [NPINS-1:0] m_in;
  logic [NPINS-1:0] m_out;
  logic             sc_wr;
  logic             rd_req;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      m_ana[p] = (mode_q[2*p +: 2] == PM_ANA);
      m_in[p]  = (mode_q[2*p +: 2] == PM_IN);
      m_out[p] = (mode_q[2*p +: 2] == PM_OUT);
    end
  end

  assign sc_wr  = req_valid && req_write && (req_addr == A_SETCLR);
  assign rd_req = req_valid && !req_write;

  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ana & (pad_oe | pad_pu_en | pad_pd_en)) == '0);  // R2
  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_in & pad_oe) == '0);  // R2
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (otype_q & pad_oe & pad_do) == '0);  // R3
  AST_PP_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (m_out & ~otype_q & ((pad_do ^ odr_q) | ~pad_oe)) == '0);  // R3
  AST_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((odr_q & $past(req_wdata[NPINS-1:0])) == $past(req_wdata[NPINS-1:0])));  // R4
  AST_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr |=> ((odr_q & $past(req_wdata[NPINS +: NPINS] & ~req_wdata[NPINS-1:0])) == '0));  // R4
  AST_SETCLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_addr == A_SETCLR) |=> (rsp_data == '0));  // R5
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu_en & pad_pd_en) == '0);  // R7
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);  // R10
  AST_NO_RSP_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);  // R10

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .NPINS (NPINS),
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .pad_oe   (pad_oe),
  .pad_do   (pad_do),
  .pad_pu_en(pad_pu_en),
  .pad_pd_en(pad_pd_en),
  .mode_q   (mode_q),
  .otype_q  (otype_q),
  .odr_q    (odr_q)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;
  import gpio_port_pkg::*;

  localparam int NP = 16;
  localparam int NS = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [3:0]     req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           rsp_valid;
  logic [31:0]    rsp_data;
  logic [NP-1:0]  pad_in = '0;
  logic [NS*NP-1:0] af_dout = '0;
  logic [NP-1:0]  pad_oe, pad_do, pad_pu_en, pad_pd_en;
  logic [2*NP-1:0] pad_speed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] s_mode, s_speed, s_pull, s_afl, s_afh;
  logic [15:0] s_ot, s_odr;

  always #5 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pad_in(pad_in), .af_dout(af_dout), .pad_oe(pad_oe),
    .pad_do(pad_do), .pad_pu_en(pad_pu_en), .pad_pd_en(pad_pd_en),
    .pad_speed(pad_speed)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act,
                     input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    case (a)
      A_MODE:   s_mode  = d;
      A_OTYPE:  s_ot    = d[15:0];
      A_SPEED:  s_speed = d;
      A_PULL:   s_pull  = d;
      A_ODR:    s_odr   = d[15:0];
      A_SETCLR: s_odr   = (s_odr & ~d[31:16]) | d[15:0];
      A_AFL:    s_afl   = d;
      A_AFH:    s_afh   = d;
      default:  ;
    endcase
    chk(rsp_valid == 1'b0, "R10 no response after write", 96'(rsp_valid), 96'(0));
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10 response one cycle after read", 96'(rsp_valid), 96'(1));
    d = rsp_data;
  endtask

  task automatic read_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    bus_read(a, d);
    chk(d == exp, req, 96'(d), 96'(exp));
  endtask

  task automatic check_pads(input string req);
    logic [NP-1:0] e_oe, e_do, e_pu, e_pd;
    for (int p = 0; p < NP; p++) begin
      logic [1:0] m;
      logic [3:0] sel;
      logic src, drv;
      m   = s_mode[2*p +: 2];
      sel = (p < 8) ? s_afl[4*p +: 4] : s_afh[4*(p-8) +: 4];
      src = (m == 2'b10) ? af_dout[int'(sel)*NP + p] : s_odr[p];
      drv = (m == 2'b01) || (m == 2'b10);
      e_oe[p] = drv && (s_ot[p] ? !src : 1'b1);
      e_do[p] = drv && !s_ot[p] && src;
      e_pu[p] = (m != 2'b11) && (s_pull[2*p +: 2] == 2'b01);
      e_pd[p] = (m != 2'b11) && (s_pull[2*p +: 2] == 2'b10);
    end
    chk({pad_oe, pad_do, pad_pu_en, pad_pd_en, pad_speed} ==
        {e_oe, e_do, e_pu, e_pd, s_speed}, req,
        {pad_oe, pad_do, pad_pu_en, pad_pd_en, pad_speed},
        {e_oe, e_do, e_pu, e_pd, s_speed});
  endtask

  function automatic logic [NS*NP-1:0] mk_af(input int seed);
    logic [NS*NP-1:0] v;
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NP; p++)
        v[s*NP + p] = ((s*5 + p*3 + seed) % 7) < 3;
    return v;
  endfunction

  function automatic logic [15:0] ana_of(input logic [31:0] m);
    logic [15:0] r;
    for (int p = 0; p < NP; p++) r[p] = (m[2*p +: 2] == 2'b11);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] odr_pat [3];
    logic [31:0] sc_pat [5];
    logic [15:0] in_pat [3];
    s_mode = '0; s_speed = '0; s_pull = '0; s_afl = '0; s_afh = '0; s_ot = '0; s_odr = '0;
    odr_pat[0] = 16'h0000; odr_pat[1] = 16'hFFFF; odr_pat[2] = 16'hA5C3;
    repeat (3) @(negedge clk);
    // R1 reset state seen on pads before and after release
    check_pads("R1 reset pads");
    rst_n = 1'b1;
    check_pads("R1 pads after reset release");
    for (int a = 0; a < 9; a++) read_chk(4'(a), 32'h0, "R1 register reset value");

    // R2 R3 function x stage type x latch pattern
    for (int m = 0; m < 4; m++)
      for (int ot = 0; ot < 2; ot++)
        for (int k = 0; k < 3; k++) begin
          bus_write(A_MODE, {16{2'(m)}});
          bus_write(A_OTYPE, ot ? 32'h0000_FFFF : 32'h0);
          bus_write(A_ODR, {16'h0, odr_pat[k]});
          check_pads(ot ? "R3 open-drain sweep" : "R2 mode sweep push-pull");
        end
    bus_write(A_MODE, 32'h9C6E_41B7);
    bus_write(A_OTYPE, 32'h0000_3C5A);
    bus_write(A_ODR, 32'h0000_0FF0);
    check_pads("R2 mixed per-pin modes");
    read_chk(A_MODE, 32'h9C6E_41B7, "R2 mode readback");
    read_chk(A_OTYPE, 32'h0000_3C5A, "R3 otype readback");

    // R4 R5 set/clear
    bus_write(A_MODE, 32'h5555_5555);
    bus_write(A_OTYPE, 32'h0);
    bus_write(A_ODR, 32'h0000_00FF);
    sc_pat[0] = 32'h0000_0F00; sc_pat[1] = 32'h000F_0000; sc_pat[2] = 32'hFFFF_0000;
    sc_pat[3] = 32'h00F0_00F0; sc_pat[4] = 32'h3C00_C3C3;
    for (int i = 0; i < 5; i++) begin
      bus_write(A_SETCLR, sc_pat[i]);
      read_chk(A_ODR, {16'h0, s_odr}, "R4 set/clear result (set wins)");
      check_pads("R4 latch on pads");
    end
    read_chk(A_SETCLR, 32'h0, "R5 set/clear reads zero");
    bus_write(A_SETCLR, 32'h0);
    read_chk(A_ODR, {16'h0, s_odr}, "R4 zero write leaves latch");

    // R6 source select sweep, push-pull then open-drain
    bus_write(A_MODE, 32'hAAAA_AAAA);
    for (int ot = 0; ot < 2; ot++) begin
      bus_write(A_OTYPE, ot ? 32'h0000_FFFF : 32'h0);
      for (int f = 0; f < NS; f++) begin
        logic [31:0] lo, hi;
        for (int p = 0; p < 8; p++) begin
          lo[4*p +: 4] = 4'((f + p) % 16);
          hi[4*p +: 4] = 4'((f + p + 8) % 16);
        end
        af_dout = mk_af(f + 11*ot);
        bus_write(A_AFL, lo);
        bus_write(A_AFH, hi);
        check_pads("R6 peripheral source select");
      end
    end
    read_chk(A_AFL, s_afl, "R6 low select readback");
    read_chk(A_AFH, s_afh, "R6 high select readback");

    // R7 pulls
    for (int pv = 0; pv < 4; pv++)
      for (int mm = 0; mm < 2; mm++) begin
        bus_write(A_MODE, mm ? 32'hFFFF_FFFF : 32'h0);
        bus_write(A_PULL, {16{2'(pv)}});
        check_pads("R7 pull enables");
      end
    bus_write(A_MODE, 32'h0F0F_3C3C);
    bus_write(A_PULL, 32'h6C93_D21E);
    check_pads("R7 mixed pulls with analog pins");

    // R9 speed codes
    bus_write(A_SPEED, 32'hE4E4_1B1B);
    check_pads("R9 speed exported");
    read_chk(A_SPEED, 32'hE4E4_1B1B, "R9 speed readback");
    bus_write(A_SPEED, 32'h5A3C_F00F);
    check_pads("R9 speed exported second pattern");

    // R8 input data through synchronizer, all functions
    in_pat[0] = 16'hFFFF; in_pat[1] = 16'h1234; in_pat[2] = 16'hC0DE;
    for (int m = 0; m < 5; m++)
      for (int k = 0; k < 3; k++) begin
        logic [31:0] mw;
        mw = (m < 4) ? {16{2'(m)}} : 32'hC3A5_0F3C;
        bus_write(A_MODE, mw);
        @(negedge clk);
        pad_in = in_pat[k];
        repeat (2) @(negedge clk);
        read_chk(A_IDR, {16'h0, in_pat[k] & ~ana_of(mw)}, "R8 input data (analog reads 0)");
      end

    // R11 unmapped words
    bus_write(4'd9, 32'hFFFF_FFFF);
    bus_write(4'd15, 32'hFFFF_FFFF);
    check_pads("R11 unmapped writes change nothing");
    read_chk(A_MODE, s_mode, "R11 mode untouched");
    read_chk(A_ODR, {16'h0, s_odr}, "R11 latch untouched");
    for (int a = 9; a < 16; a++) read_chk(4'(a), 32'h0, "R11 unmapped reads zero");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule